// File: doc/BRIEF.md
# Delay Line Tap Update Controller

This block owns the tap count that programs a digital delay line on one I/O lane. After reset it puts a start-up tap value on the line, then accepts runtime changes through a load strobe with a parallel value, and through single-tap steps up or down. A delay-kind parameter decides which of these controls are honoured. A commit-rule parameter decides when an accepted change reaches the line: at once, only at a transition on the lane's serial data, or through a two-step capture-then-confirm sequence that lets software choose a quiet moment.

The start-up value is given either directly in taps or as a delay in picoseconds. In picosecond form the request is first clamped to a device ceiling. It is then turned into taps with a calibrated taps-per-reference-period figure from an external calibration engine, divided by the reference clock period. A serial divider does this conversion. The ready flag stays low until the start-up value is on the line. The clock and reset inputs each carry a parameter-selected polarity inversion.

The state machine has five states. ST_INIT is the post-reset state. ST_CONV means the divider is running. ST_IDLE means nothing is outstanding. ST_PEND means an edge-rule change is waiting. ST_ARMED means a two-step value has been captured. The transitions are:
- INIT to IDLE in tap format.
- INIT to CONV when calibration is valid in picosecond format.
- CONV to IDLE when the division is done.
- IDLE or PEND to PEND when a request arrives without an edge.
- PEND to IDLE at an edge.
- IDLE or ARMED to ARMED on a capture load.
- ARMED to IDLE on a confirm.
- Any state to INIT on reset.

Top module: `tap_delay_ctrl`

## Requirements
- R1: While reset is active, `cnt_out` holds the start-up tap value (DELAY_VALUE in tap format, 0 in picosecond format) and `ready` is 0. Any pending or captured value is discarded. In tap format, `ready` is 1 after the first rising clock edge that samples reset inactive.
- R2: With DLY_KIND = DLY_FIXED, `load`, `ce`, `inc`, `cnt_in` and `din` never change `cnt_out`.
- R3: With DLY_KIND = DLY_LOAD_ONLY, a `load` requests `cnt_in` as the new tap count. `ce` and `inc` without `load` request nothing.
- R4: With DLY_KIND = DLY_VARIABLE, a cycle with `ce`=1 and `load`=0 requests the current count plus one when `inc`=1, and minus one when `inc`=0. When `load` and `ce` are both 1, the load wins.
- R5: Steps saturate at 0 and at 2^TAP_W-1 (511 by default) and never wrap.
- R6: With UPD_RULE = UPD_IMMEDIATE, a request sampled at a rising edge is on `cnt_out` right after that edge, whatever `din` does.
- R7: With UPD_RULE = UPD_ON_EDGE, a request is held as pending. It is committed at the first rising edge where `din` differs from its value at the previous edge (the register holding the previous value resets to 0). A later request replaces the pending value, and a step is taken from the pending value. A request in a cycle that already has an edge is committed at that edge.
- R8: With UPD_RULE = UPD_TWO_STEP, a `load` captures `cnt_in` without changing `cnt_out`, and another `load` without `ce` replaces the captured value. A `load` with `ce`=1 while a value is captured commits the captured value. A step (R4) applies at once.
- R9: `cnt_out` shows only committed values, never pending or captured ones. `line_tap` always equals `cnt_out`.
- R10: In picosecond format, `ready` stays 0 and `cnt_out` stays 0 until `cal_valid` is seen and the conversion ends. The count then becomes min(2^TAP_W-1, floor(min(DELAY_VALUE, MAX_PS) * cal_taps / REF_PERIOD_PS)).
- R11: With CLK_INV=1 and RST_INV=1, the block acts on falling edges of `clk` and treats `rst` low as reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, polarity set by CLK_INV |
| rst | input | 1 | Synchronous reset, polarity set by RST_INV |
| din | input | 1 | Lane serial data, used for edge detection |
| load | input | 1 | Load or capture strobe |
| ce | input | 1 | Step enable, also confirm qualifier in two-step rule |
| inc | input | 1 | Step direction, 1 = up |
| cnt_in | input | TAP_W | Tap value to load |
| cal_valid | input | 1 | Calibration result valid |
| cal_taps | input | CAL_W | Calibrated taps per reference period |
| cnt_out | output | TAP_W | Committed tap count |
| line_tap | output | TAP_W | Tap setting driven to the delay line |
| ready | output | 1 | Start-up value applied |

## Verification
The bench builds seven copies side by side:
- Variable delay with the immediate, edge and two-step commit rules, with start-up values of 100, 5 and 500.
- A load-only copy.
- A fixed copy with both polarity inversions set.
- Two fixed picosecond-format copies. One has a request over its 1250 ps ceiling; the other has a 1100 ps ceiling and a result above 511.

This lets one shared random stream cover every commit rule and delay kind at once. Directed cycles reach both saturation ends, load priority over a step, replacement of a pending or captured value, the clamp and saturation in the picosecond conversion, and a reset in the middle of traffic.

// File: rtl/tap_pkg.sv
package tap_pkg;
    typedef enum logic [1:0] {
        DLY_FIXED,
        DLY_LOAD_ONLY,
        DLY_VARIABLE
    } dly_kind_e;

    typedef enum logic [1:0] {
        UPD_IMMEDIATE,
        UPD_ON_EDGE,
        UPD_TWO_STEP
    } upd_rule_e;

    typedef enum logic [2:0] {
        ST_INIT,
        ST_CONV,
        ST_IDLE,
        ST_PEND,
        ST_ARMED
    } ctl_state_e;
endpackage

// File: rtl/tap_edge_det.sv
module tap_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic din_edge
);
    logic din_q;

    always_ff @(posedge clk) begin
        if (rst) din_q <= 1'b0;
        else     din_q <= din;
    end

    assign din_edge = din ^ din_q;
endmodule

// File: rtl/tap_ps_conv.sv
module tap_ps_conv #(
    parameter int NUM_W = 23,
    parameter int TAP_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [NUM_W-1:0] den,
    output logic             done,
    output logic [TAP_W-1:0] taps
);
    localparam int CW      = $clog2(NUM_W + 1);
    localparam int TAP_MAX = (1 << TAP_W) - 1;

    logic [NUM_W-1:0] rem_q;
    logic [NUM_W-1:0] quo_q;
    logic [CW-1:0]    cnt_q;
    logic             busy_q;
    logic             done_q;
    logic [NUM_W:0]   rem_sh;
    logic             fits;

    assign rem_sh = {rem_q, quo_q[NUM_W-1]};
    assign fits   = rem_sh >= {1'b0, den};

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            quo_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                rem_q  <= '0;
                quo_q  <= num;
                cnt_q  <= CW'(NUM_W);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                rem_q  <= fits ? NUM_W'(rem_sh - {1'b0, den}) : rem_sh[NUM_W-1:0];
                quo_q  <= {quo_q[NUM_W-2:0], fits};
                cnt_q  <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign done = done_q;
    assign taps = (quo_q > NUM_W'(TAP_MAX)) ? TAP_W'(TAP_MAX) : quo_q[TAP_W-1:0];

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: rtl/tap_active_reg.sv
module tap_active_reg #(
    parameter int TAP_W    = 9,
    parameter int INIT_TAP = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             commit,
    input  logic [TAP_W-1:0] commit_val,
    output logic [TAP_W-1:0] cur
);
    always_ff @(posedge clk) begin
        if (rst)         cur <= TAP_W'(INIT_TAP);
        else if (commit) cur <= commit_val;
    end

    p_hold_without_commit_r9: assert property (@(posedge clk) disable iff (rst)
        !$past(commit) && !$past(rst) |-> $stable(cur));
endmodule

// File: rtl/tap_delay_ctrl.sv
module tap_delay_ctrl
    import tap_pkg::*;
#(
    parameter dly_kind_e DLY_KIND      = DLY_VARIABLE,
    parameter upd_rule_e UPD_RULE      = UPD_IMMEDIATE,
    parameter bit        TIME_FMT      = 1'b0,
    parameter int        TAP_W         = 9,
    parameter int        DELAY_VALUE   = 0,
    parameter int        MAX_PS        = 1250,
    parameter int        PS_W          = 11,
    parameter int        CAL_W         = 12,
    parameter int        REF_PERIOD_PS = 3333,
    parameter bit        CLK_INV       = 1'b0,
    parameter bit        RST_INV       = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             din,
    input  logic             load,
    input  logic             ce,
    input  logic             inc,
    input  logic [TAP_W-1:0] cnt_in,
    input  logic             cal_valid,
    input  logic [CAL_W-1:0] cal_taps,
    output logic [TAP_W-1:0] cnt_out,
    output logic [TAP_W-1:0] line_tap,
    output logic             ready
);
    localparam int TAP_MAX  = (1 << TAP_W) - 1;
    localparam int PS_EFF   = (DELAY_VALUE > MAX_PS) ? MAX_PS : DELAY_VALUE;
    localparam int NUM_W    = PS_W + CAL_W;
    localparam int INIT_TAP = TIME_FMT ? 0 : DELAY_VALUE;

    logic clk_i;
    logic rst_i;

    generate
        if (CLK_INV) begin : g_clk_inv
            assign clk_i = ~clk;
        end else begin : g_clk_dir
            assign clk_i = clk;
        end
        if (RST_INV) begin : g_rst_inv
            assign rst_i = ~rst;
        end else begin : g_rst_dir
            assign rst_i = rst;
        end
    endgenerate

    ctl_state_e       state, state_nx;
    logic [TAP_W-1:0] cur;
    logic [TAP_W-1:0] stash, stash_nx;
    logic             stash_we;
    logic             commit;
    logic [TAP_W-1:0] commit_val;
    logic             conv_start;
    logic             conv_done;
    logic [TAP_W-1:0] conv_taps;
    logic [NUM_W-1:0] conv_num;
    logic [NUM_W-1:0] conv_den;
    logic             din_edge;
    logic             req_load, req_step, req_any;
    logic [TAP_W-1:0] base, step_val, req_val, pend_val;

    tap_edge_det u_edge (
        .clk      (clk_i),
        .rst      (rst_i),
        .din      (din),
        .din_edge (din_edge)
    );

    assign conv_num = NUM_W'(PS_EFF) * {{PS_W{1'b0}}, cal_taps};
    assign conv_den = NUM_W'(REF_PERIOD_PS);

    tap_ps_conv #(.NUM_W(NUM_W), .TAP_W(TAP_W)) u_conv (
        .clk   (clk_i),
        .rst   (rst_i),
        .start (conv_start),
        .num   (conv_num),
        .den   (conv_den),
        .done  (conv_done),
        .taps  (conv_taps)
    );

    tap_active_reg #(.TAP_W(TAP_W), .INIT_TAP(INIT_TAP)) u_active (
        .clk        (clk_i),
        .rst        (rst_i),
        .commit     (commit),
        .commit_val (commit_val),
        .cur        (cur)
    );

    // request decode: what the delay kind lets through
    assign req_load = load && (DLY_KIND != DLY_FIXED);
    assign req_step = ce && !load && (DLY_KIND == DLY_VARIABLE);
    assign req_any  = req_load || req_step;

    assign base     = (state == ST_PEND) ? stash : cur;
    assign step_val = inc ? ((base == TAP_W'(TAP_MAX)) ? base : base + 1'b1)
                          : ((base == '0) ? base : base - 1'b1);
    assign req_val  = req_load ? cnt_in : step_val;
    assign pend_val = req_any ? req_val : stash;

    // state register
    always_ff @(posedge clk_i) begin
        if (rst_i) state <= ST_INIT;
        else       state <= state_nx;
    end

    // next state and commit decisions
    always_comb begin
        state_nx   = state;
        commit     = 1'b0;
        commit_val = cur;
        stash_we   = 1'b0;
        stash_nx   = stash;
        conv_start = 1'b0;
        unique case (state)
            ST_INIT: begin
                if (TIME_FMT) begin
                    if (cal_valid) begin
                        conv_start = 1'b1;
                        state_nx   = ST_CONV;
                    end
                end else begin
                    state_nx = ST_IDLE;
                end
            end
            ST_CONV: begin
                if (conv_done) begin
                    commit     = 1'b1;
                    commit_val = conv_taps;
                    state_nx   = ST_IDLE;
                end
            end
            ST_IDLE, ST_PEND, ST_ARMED: begin
                if (UPD_RULE == UPD_IMMEDIATE) begin
                    if (req_any) begin
                        commit     = 1'b1;
                        commit_val = req_val;
                    end
                end else if (UPD_RULE == UPD_ON_EDGE) begin
                    if (req_any || state == ST_PEND) begin
                        if (din_edge) begin
                            commit     = 1'b1;
                            commit_val = pend_val;
                            state_nx   = ST_IDLE;
                        end else begin
                            stash_we = 1'b1;
                            stash_nx = pend_val;
                            state_nx = ST_PEND;
                        end
                    end
                end else begin
                    if (req_load) begin
                        if (state == ST_ARMED && ce) begin
                            commit     = 1'b1;
                            commit_val = stash;
                            state_nx   = ST_IDLE;
                        end else begin
                            stash_we = 1'b1;
                            stash_nx = cnt_in;
                            state_nx = ST_ARMED;
                        end
                    end else if (req_step) begin
                        commit     = 1'b1;
                        commit_val = step_val;
                    end
                end
            end
            default: state_nx = ST_INIT;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)         stash <= '0;
        else if (stash_we) stash <= stash_nx;
    end

    // outputs
    always_comb begin
        ready    = (state == ST_IDLE) || (state == ST_PEND) || (state == ST_ARMED);
        cnt_out  = cur;
        line_tap = cur;
    end

    p_reset_ready_low_r1: assert property (@(posedge clk_i)
        rst_i |=> !ready);
    p_reset_value_r1: assert property (@(posedge clk_i)
        rst_i |=> cnt_out == TAP_W'(INIT_TAP));

    generate
        if (DLY_KIND == DLY_FIXED) begin : g_chk_fixed
            p_fixed_hold_r2: assert property (@(posedge clk_i) disable iff (rst_i)
                ready && $past(ready) |-> $stable(cnt_out));
        end
        if (DLY_KIND == DLY_LOAD_ONLY && UPD_RULE != UPD_ON_EDGE) begin : g_chk_load
            p_no_step_r3: assert property (@(posedge clk_i) disable iff (rst_i)
                $past(ready) && !$past(load) |-> $stable(cnt_out));
        end
        if (DLY_KIND == DLY_VARIABLE && UPD_RULE != UPD_ON_EDGE) begin : g_chk_sat
            p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (rst_i)
                $past(ready && ce && !load && inc) && $past(cnt_out) == TAP_W'(TAP_MAX)
                |-> cnt_out == TAP_W'(TAP_MAX));
            p_no_underflow_r5: assert property (@(posedge clk_i) disable iff (rst_i)
                $past(ready && ce && !load && !inc) && $past(cnt_out) == '0
                |-> cnt_out == '0);
        end
        if (UPD_RULE == UPD_ON_EDGE && !TIME_FMT) begin : g_chk_edge
            p_commit_on_edge_r7: assert property (@(posedge clk_i) disable iff (rst_i)
                $past(ready) && !$stable(cnt_out) |-> $past(din_edge));
        end
        if (UPD_RULE == UPD_TWO_STEP && !TIME_FMT) begin : g_chk_manual
            p_capture_no_change_r8: assert property (@(posedge clk_i) disable iff (rst_i)
                $past(ready && load && !ce) |-> $stable(cnt_out));
        end
    endgenerate
endmodule

// File: tb/tap_delay_ctrl_bench.sv
module tap_delay_ctrl_bench;
    import tap_pkg::*;

    localparam int CLK_P = 10;
    localparam int NI    = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       din = 1'b0, load = 1'b0, ce = 1'b0, inc = 1'b0, cal_valid = 1'b0;
    logic [8:0] cnt_in = '0;
    logic [11:0] cal_taps = 12'd667;
    logic       clk_n, rst_n;
    logic [8:0] co [7];
    logic [8:0] lt [7];
    logic       rd [7];

    int n_cmp = 0;
    int n_bad = 0;

    assign clk_n = ~clk;
    assign rst_n = ~rst;

    always #(CLK_P/2) clk = ~clk;

    tap_delay_ctrl #(.DLY_KIND(DLY_VARIABLE), .UPD_RULE(UPD_IMMEDIATE), .DELAY_VALUE(100)) u_tap_delay_ctrl (
        .clk(clk), .rst(rst), .din(din), .load(load), .ce(ce), .inc(inc), .cnt_in(cnt_in),
        .cal_valid(cal_valid), .cal_taps(cal_taps), .cnt_out(co[0]), .line_tap(lt[0]), .ready(rd[0]));
    tap_delay_ctrl #(.DLY_KIND(DLY_VARIABLE), .UPD_RULE(UPD_ON_EDGE), .DELAY_VALUE(5)) u_sync (
        .clk(clk), .rst(rst), .din(din), .load(load), .ce(ce), .inc(inc), .cnt_in(cnt_in),
        .cal_valid(cal_valid), .cal_taps(cal_taps), .cnt_out(co[1]), .line_tap(lt[1]), .ready(rd[1]));
    tap_delay_ctrl #(.DLY_KIND(DLY_VARIABLE), .UPD_RULE(UPD_TWO_STEP), .DELAY_VALUE(500)) u_man (
        .clk(clk), .rst(rst), .din(din), .load(load), .ce(ce), .inc(inc), .cnt_in(cnt_in),
        .cal_valid(cal_valid), .cal_taps(cal_taps), .cnt_out(co[2]), .line_tap(lt[2]), .ready(rd[2]));
    tap_delay_ctrl #(.DLY_KIND(DLY_LOAD_ONLY), .UPD_RULE(UPD_IMMEDIATE), .DELAY_VALUE(0)) u_vl (
        .clk(clk), .rst(rst), .din(din), .load(load), .ce(ce), .inc(inc), .cnt_in(cnt_in),
        .cal_valid(cal_valid), .cal_taps(cal_taps), .cnt_out(co[3]), .line_tap(lt[3]), .ready(rd[3]));
    tap_delay_ctrl #(.DLY_KIND(DLY_FIXED), .DELAY_VALUE(321), .CLK_INV(1'b1), .RST_INV(1'b1)) u_fix (
        .clk(clk_n), .rst(rst_n), .din(din), .load(load), .ce(ce), .inc(inc), .cnt_in(cnt_in),
        .cal_valid(cal_valid), .cal_taps(cal_taps), .cnt_out(co[4]), .line_tap(lt[4]), .ready(rd[4]));
    tap_delay_ctrl #(.DLY_KIND(DLY_FIXED), .TIME_FMT(1'b1), .DELAY_VALUE(1400), .MAX_PS(1250),
                     .REF_PERIOD_PS(3333)) u_tm (
        .clk(clk), .rst(rst), .din(din), .load(load), .ce(ce), .inc(inc), .cnt_in(cnt_in),
        .cal_valid(cal_valid), .cal_taps(cal_taps), .cnt_out(co[5]), .line_tap(lt[5]), .ready(rd[5]));
    tap_delay_ctrl #(.DLY_KIND(DLY_FIXED), .TIME_FMT(1'b1), .DELAY_VALUE(1000), .MAX_PS(1100),
                     .REF_PERIOD_PS(1250)) u_tm2 (
        .clk(clk), .rst(rst), .din(din), .load(load), .ce(ce), .inc(inc), .cnt_in(cnt_in),
        .cal_valid(cal_valid), .cal_taps(cal_taps), .cnt_out(co[6]), .line_tap(lt[6]), .ready(rd[6]));

    // reference model: 0 fixed / 1 load only / 2 variable ; 0 immediate / 1 edge / 2 two-step
    // state: 0 init, 1 idle, 2 pending, 3 captured
    int    kind [NI] = '{2, 2, 2, 1, 0};
    int    rule [NI] = '{0, 1, 2, 0, 0};
    int    dflt [NI] = '{100, 5, 500, 0, 321};
    string tagv [NI] = '{"R6", "R7", "R8", "R3", "R2"};
    int    m_cur [NI];
    int    m_stash [NI];
    int    m_st [NI];
    int    m_dinq = 0;

    function automatic int sat_step(int v, bit up);
        if (up) return (v == 511) ? 511 : v + 1;
        return (v == 0) ? 0 : v - 1;
    endfunction

    function automatic int exp_conv(int ps, int mx, int cal, int per);
        int p = (ps > mx) ? mx : ps;
        int q = (p * cal) / per;
        return (q > 511) ? 511 : q;
    endfunction

    always @(posedge clk) begin
        for (int i = 0; i < NI; i++) begin
            bit rl, rs, has;
            int bs, nv;
            rl = load && kind[i] != 0;
            rs = ce && !load && kind[i] == 2;
            if (rst) begin
                m_st[i] = 0; m_cur[i] = dflt[i]; m_stash[i] = 0;
            end else if (m_st[i] == 0) begin
                m_st[i] = 1;
            end else if (rule[i] == 0) begin
                if (rl) m_cur[i] = int'(cnt_in);
                else if (rs) m_cur[i] = sat_step(m_cur[i], inc);
            end else if (rule[i] == 1) begin
                bs  = (m_st[i] == 2) ? m_stash[i] : m_cur[i];
                has = rl || rs || m_st[i] == 2;
                nv  = rl ? int'(cnt_in) : (rs ? sat_step(bs, inc) : m_stash[i]);
                if (has) begin
                    if (int'(din) != m_dinq) begin m_cur[i] = nv; m_st[i] = 1; end
                    else begin m_stash[i] = nv; m_st[i] = 2; end
                end
            end else begin
                if (rl) begin
                    if (m_st[i] == 3 && ce) begin m_cur[i] = m_stash[i]; m_st[i] = 1; end
                    else begin m_stash[i] = int'(cnt_in); m_st[i] = 3; end
                end else if (rs) m_cur[i] = sat_step(m_cur[i], inc);
            end
        end
        m_dinq = rst ? 0 : int'(din);
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic cmp_all();
        for (int i = 0; i < NI; i++) begin
            chk(tagv[i], int'(co[i]), m_cur[i]);
            chk(tagv[i], int'(rd[i]), int'(m_st[i] != 0));
            chk("R9", int'(lt[i]), int'(co[i]));
        end
    endtask

    task automatic cyc(input bit l, input bit c, input bit i, input int v, input bit d);
        load = l; ce = c; inc = i; cnt_in = 9'(v); din = d;
        @(negedge clk);
        cmp_all();
    endtask

    task automatic rand_run(input int n);
        for (int k = 0; k < n; k++) begin
            int v;
            v = ($urandom % 4 == 0) ? (($urandom % 2 == 1) ? 511 : 0) : int'($urandom % 512);
            cyc(($urandom % 8) == 0, ($urandom % 4) == 0, ($urandom % 2) == 1, v,
                (($urandom % 6) == 0) ? ~din : din);
        end
    endtask

    task automatic wait_time_ready();
        bit seen = 0;
        for (int k = 0; k < 200 && !seen; k++) begin
            cyc(0, 0, 0, 0, din);
            if (!rd[5]) chk("R10", int'(co[5]), 0);
            seen = rd[5] && rd[6];
        end
        chk("R10", int'(seen), 1);
        chk("R10", int'(co[5]), exp_conv(1400, 1250, 667, 3333));
        chk("R10", int'(co[6]), exp_conv(1000, 1100, 667, 1250));
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        int prev;
        int unsigned seed_init;
        seed_init = $urandom(32'd1729);
        repeat (3) @(negedge clk);
        // R1 / R11 / R10 reset state
        chk("R1", int'(co[0]), 100);
        chk("R1", int'(rd[0]), 0);
        chk("R11", int'(co[4]), 321);
        chk("R11", int'(rd[4]), 0);
        chk("R10", int'(co[5]), 0);
        rst = 1'b0;
        cyc(0, 0, 0, 0, 0);
        chk("R1", int'(rd[0]), 1);
        chk("R11", int'(rd[4]), 1);
        chk("R10", int'(rd[5]), 0);
        // R5 / R4 on the immediate copy
        cyc(1, 0, 0, 511, 0);  chk("R6", int'(co[0]), 511);
        cyc(0, 1, 1, 0, 0);    chk("R5", int'(co[0]), 511);
        cyc(0, 1, 0, 0, 0);    chk("R4", int'(co[0]), 510);
        cyc(1, 0, 0, 0, 0);    chk("R6", int'(co[0]), 0);
        cyc(0, 1, 0, 0, 0);    chk("R5", int'(co[0]), 0);
        cyc(1, 1, 1, 40, 0);   chk("R4", int'(co[0]), 40);
        cyc(0, 1, 1, 0, 0);    chk("R3", int'(co[3]), 40); chk("R4", int'(co[0]), 41);
        // R8 two-step
        prev = int'(co[2]);
        cyc(1, 0, 0, 77, 0);   chk("R8", int'(co[2]), prev);
        cyc(1, 0, 0, 88, 0);   chk("R8", int'(co[2]), prev);
        cyc(1, 1, 0, 5, 0);    chk("R8", int'(co[2]), 88);
        // R7 / R9 edge rule: din has stayed 0, nothing committed yet
        chk("R9", int'(co[1]), 5);
        cyc(1, 0, 0, 200, 0);  chk("R9", int'(co[1]), 5);
        cyc(0, 0, 0, 0, 1);    chk("R7", int'(co[1]), 200);
        cyc(0, 1, 1, 0, 1);    chk("R9", int'(co[1]), 200);
        cyc(0, 0, 0, 0, 0);    chk("R7", int'(co[1]), 201);
        cyc(1, 0, 0, 33, 1);   chk("R7", int'(co[1]), 33);
        chk("R2", int'(co[4]), 321);
        // R10 picosecond conversion
        cal_valid = 1'b1;
        wait_time_ready();
        rand_run(4000);
        // reset in the middle of traffic
        rst = 1'b1;
        cyc(1, 1, 1, 300, ~din);
        cyc(1, 0, 0, 301, din);
        chk("R1", int'(co[0]), 100);
        chk("R1", int'(co[2]), 500);
        chk("R1", int'(rd[1]), 0);
        rst = 1'b0;
        cyc(0, 0, 0, 0, 0);
        chk("R10", int'(rd[5]), 0);
        chk("R1", int'(co[1]), 5);
        wait_time_ready();
        rand_run(1500);
        summary();
        $finish;
    end
endmodule